// File: doc/BRIEF.md
# Outbound Write Parity Error Handler

This block is the error-response logic that sits beside a bus master's outbound write engine. While the master runs a write it initiated, the block watches the target's parity-error indication. When an error is accepted, it records sticky status and interrupt bits and decides whether to raise a one-cycle system-error pulse. It also tells the write engine how to finish the transaction: keep draining the write queue, retry after a disconnect, and whether a master completion may be reported.

Two kinds of write are handled. An ordinary write that sees a data error keeps streaming its data until the queue entry is empty. It gets no completion, and it raises system error only in split-capable bus mode with recovery disabled. An interrupt-message write completes normally. Its error is acted on at the cycle the transaction ends, and it raises system error whenever system error is enabled. A parity error reported after a split-response termination of a non-posted write is handled like an ordinary in-transaction error.

Top module: `owr_err_resp`

## Requirements
- R1: After reset, `err_sts` is 0 and `serr_pulse`, `retry_req`, `cpl_ok` and `drain_hold` are low.
- R2: A parity error accepted while `en_perr_resp` is 1 sets `err_sts[0]` (master parity error) on the next edge. With `en_perr_resp` at 0, the error changes no status bit, raises no pulse and starts no draining.
- R3: `err_sts[2]` (master parity interrupt) is set together with `err_sts[0]` only when `mask_mpe` is 0.
- R4: For an ordinary write (`txn_is_msg`=0), `serr_pulse` fires only if `mode_split`=1, `en_serr`=1 and `en_recov`=0.
- R5: For an interrupt-message write, the error takes effect on the edge where `txn_end` is sampled. `serr_pulse` fires if `en_serr`=1, whatever the mode and `en_recov`, and `cpl_ok` still pulses.
- R6: Every `serr_pulse` sets `err_sts[1]` (system error asserted). It also sets `err_sts[3]` when `mask_serr` is 0.
- R7: Every `serr_pulse` sets `err_sts[4]` (system error detected interrupt) when `en_serr_det_int` is 1.
- R8: After an accepted error on an ordinary write, `drain_hold` stays high until the transaction ends, and no `cpl_ok` pulse is given for it. A write with no accepted error gives one `cpl_ok` pulse after `txn_end`.
- R9: A `disc_in` during an ordinary write that has an accepted error gives a one-cycle `retry_req` on the next cycle. A disconnect on a clean write gives none.
- R10: `split_perr` is handled as an ordinary-write error when `mode_split`=1, and is ignored when `mode_split`=0.
- R11: Writing 1 to a bit of `err_clr` clears that status bit on the next edge. A bit being set in the same cycle stays set.
- R12: At most one error event is recorded per transaction, however many data phases report parity errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | Pulse: an outbound write transaction begins |
| txn_is_msg | input | 1 | Type of the starting write: 1 = interrupt message |
| txn_end | input | 1 | Pulse: last data of the transaction leaves the queue |
| perr_in | input | 1 | Target parity error sampled this data phase |
| split_perr | input | 1 | Parity error reported after a split response |
| disc_in | input | 1 | Target disconnected the current write |
| mode_split | input | 1 | 1 = split-capable bus mode, 0 = conventional |
| en_perr_resp | input | 1 | Parity-error response enable |
| en_serr | input | 1 | System-error enable |
| en_recov | input | 1 | Uncorrectable data error recovery enable |
| en_serr_det_int | input | 1 | System-error detected interrupt enable |
| mask_mpe | input | 1 | Master parity interrupt mask |
| mask_serr | input | 1 | System-error asserted interrupt mask |
| err_clr | input | 5 | Write-one-to-clear strobes for `err_sts` |
| err_sts | output | 5 | [0] parity, [1] sys-err asserted, [2] parity int, [3] sys-err int, [4] sys-err detected int |
| serr_pulse | output | 1 | One-cycle system-error output |
| drain_hold | output | 1 | Keep issuing data of the errored write |
| retry_req | output | 1 | Reinitiate the disconnected errored write |
| cpl_ok | output | 1 | Master completion may be reported |

## Verification
The block's only size constant is the five-bit status width from the package, so the bench builds it with that default. At this width the full status vector can be compared in one step. Eight table rows cover the escalation matrix: both write types, both modes, the recovery enable, and each mask and enable. Each row compares the whole status vector, the number of system-error pulses and the number of completions. Directed cases then cover the disabled response, the collision between a clear and a set, late split-response errors in each mode, repeated errors within one transaction, and disconnects with and without an error.

// File: rtl/owr_err_pkg.sv
package owr_err_pkg;

    localparam int STS_W    = 5;
    localparam int B_MPE    = 0;
    localparam int B_SERR   = 1;
    localparam int B_IMPE   = 2;
    localparam int B_ISERR  = 3;
    localparam int B_IDET   = 4;

    typedef struct packed {
        logic valid;
        logic is_msg;
    } err_evt_t;

    typedef struct packed {
        logic mode_split;
        logic en_serr;
        logic en_recov;
    } esc_cfg_t;

    function automatic logic serr_decide(err_evt_t e, esc_cfg_t c);
        if (!e.valid || !c.en_serr) return 1'b0;
        if (e.is_msg) return 1'b1;
        return c.mode_split && !c.en_recov;
    endfunction

endpackage

// File: rtl/owr_txn_track.sv
module owr_txn_track
    import owr_err_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     txn_start,
    input  logic     txn_is_msg,
    input  logic     txn_end,
    input  logic     perr_in,
    input  logic     split_perr,
    input  logic     disc_in,
    input  logic     mode_split,
    input  logic     en_perr_resp,
    output err_evt_t evt,
    output logic     drain_hold,
    output logic     retry_req,
    output logic     cpl_ok
);
    logic active, is_msg, err_seen, msg_pend;
    logic acc, ord_evt, msg_evt, errored;

    always_comb begin
        acc       = active && en_perr_resp && perr_in && !err_seen;
        ord_evt   = (acc && !is_msg) || (split_perr && mode_split && en_perr_resp);
        msg_evt   = active && is_msg && txn_end && (msg_pend || acc);
        evt.valid = ord_evt || msg_evt;
        evt.is_msg = msg_evt;
        errored   = err_seen || acc;
    end

    assign drain_hold = active && !is_msg && err_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            is_msg    <= 1'b0;
            err_seen  <= 1'b0;
            msg_pend  <= 1'b0;
            retry_req <= 1'b0;
            cpl_ok    <= 1'b0;
        end else begin
            retry_req <= active && !is_msg && errored && disc_in;
            cpl_ok    <= active && txn_end && (is_msg || !errored);
            if (txn_start && !active) begin
                active   <= 1'b1;
                is_msg   <= txn_is_msg;
                err_seen <= 1'b0;
                msg_pend <= 1'b0;
            end else if (active) begin
                if (acc) begin
                    err_seen <= 1'b1;
                    if (is_msg) msg_pend <= 1'b1;
                end
                if (txn_end) begin
                    active   <= 1'b0;
                    msg_pend <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/owr_escalate.sv
module owr_escalate
    import owr_err_pkg::*;
(
    input  err_evt_t   evt,
    input  esc_cfg_t   cfg,
    input  logic       mask_mpe,
    input  logic       mask_serr,
    input  logic       en_serr_det_int,
    output logic       serr_now,
    output logic [STS_W-1:0] set_vec
);
    always_comb begin
        serr_now         = serr_decide(evt, cfg);
        set_vec          = '0;
        set_vec[B_MPE]   = evt.valid;
        set_vec[B_IMPE]  = evt.valid && !mask_mpe;
        set_vec[B_SERR]  = serr_now;
        set_vec[B_ISERR] = serr_now && !mask_serr;
        set_vec[B_IDET]  = serr_now && en_serr_det_int;
    end
endmodule

// File: rtl/owr_sts_regs.sv
module owr_sts_regs #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] sts
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)             sts[i] <= 1'b0;
            else if (set_vec[i]) sts[i] <= 1'b1;
            else if (clr_vec[i]) sts[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/owr_err_resp.sv
module owr_err_resp
    import owr_err_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             txn_start,
    input  logic             txn_is_msg,
    input  logic             txn_end,
    input  logic             perr_in,
    input  logic             split_perr,
    input  logic             disc_in,
    input  logic             mode_split,
    input  logic             en_perr_resp,
    input  logic             en_serr,
    input  logic             en_recov,
    input  logic             en_serr_det_int,
    input  logic             mask_mpe,
    input  logic             mask_serr,
    input  logic [STS_W-1:0] err_clr,
    output logic [STS_W-1:0] err_sts,
    output logic             serr_pulse,
    output logic             drain_hold,
    output logic             retry_req,
    output logic             cpl_ok
);
    err_evt_t         evt;
    esc_cfg_t         cfg;
    logic             serr_now;
    logic [STS_W-1:0] set_vec;

    assign cfg = '{mode_split: mode_split, en_serr: en_serr, en_recov: en_recov};

    owr_txn_track i_track (
        .clk(clk), .rst(rst), .txn_start(txn_start), .txn_is_msg(txn_is_msg),
        .txn_end(txn_end), .perr_in(perr_in), .split_perr(split_perr),
        .disc_in(disc_in), .mode_split(mode_split), .en_perr_resp(en_perr_resp),
        .evt(evt), .drain_hold(drain_hold), .retry_req(retry_req), .cpl_ok(cpl_ok)
    );

    owr_escalate i_esc (
        .evt(evt), .cfg(cfg), .mask_mpe(mask_mpe), .mask_serr(mask_serr),
        .en_serr_det_int(en_serr_det_int), .serr_now(serr_now), .set_vec(set_vec)
    );

    owr_sts_regs #(.W(STS_W)) i_sts (
        .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(err_clr), .sts(err_sts)
    );

    always_ff @(posedge clk) begin
        if (rst) serr_pulse <= 1'b0;
        else     serr_pulse <= serr_now;
    end
endmodule

// File: rtl/owr_err_chk.sv
module owr_err_chk (
    input logic       clk,
    input logic       rst,
    input logic       disc_in,
    input logic       en_perr_resp,
    input logic       mask_mpe,
    input logic [4:0] err_sts,
    input logic       serr_pulse,
    input logic       drain_hold,
    input logic       retry_req,
    input logic       cpl_ok
);
    AST_PERR_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $rose(err_sts[0]) |-> $past(en_perr_resp)); // R2
    AST_IMPE_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        $rose(err_sts[2]) |-> $past(!mask_mpe)); // R3
    AST_SERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        serr_pulse |-> err_sts[1]); // R6
    AST_SERR_HAS_MPE: assert property (@(posedge clk) disable iff (rst)
        serr_pulse |-> err_sts[0]); // R2
    AST_DET_FROM_SERR: assert property (@(posedge clk) disable iff (rst)
        $rose(err_sts[4]) |-> serr_pulse); // R7
    AST_NO_CPL_DRAIN: assert property (@(posedge clk) disable iff (rst)
        drain_hold |=> !cpl_ok); // R8
    AST_RETRY_CAUSE: assert property (@(posedge clk) disable iff (rst)
        retry_req |-> $past(disc_in)); // R9
endmodule

bind owr_err_resp owr_err_chk i_chk (.*);

// File: tb/test_owr_err_resp.sv
module test_owr_err_resp;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic txn_start = 0, txn_is_msg = 0, txn_end = 0, perr_in = 0, split_perr = 0, disc_in = 0;
    logic mode_split = 0, en_perr_resp = 0, en_serr = 0, en_recov = 0, en_serr_det_int = 0;
    logic mask_mpe = 0, mask_serr = 0;
    logic [4:0] err_clr = '0;
    logic [4:0] err_sts;
    logic serr_pulse, drain_hold, retry_req, cpl_ok;

    int n_chk = 0, n_bad = 0;
    int serr_cnt = 0, cpl_cnt = 0, retry_cnt = 0;

    always #2.5 clk = ~clk;

    owr_err_resp i_owr_err_resp (.*);

    always @(posedge clk) begin
        #1;
        if (serr_pulse) serr_cnt++;
        if (cpl_ok)     cpl_cnt++;
        if (retry_req)  retry_cnt++;
    end

    // [12]msg [11]split [10]en_serr [9]recov [8]mask_mpe [7]mask_serr [6]det_en | [5]serr | [4:0]sts
    localparam logic [12:0] VEC [8] = '{
        13'b0110001_1_11111,
        13'b0010001_0_00101,
        13'b0111100_0_00001,
        13'b0100001_0_00101,
        13'b1011111_1_10011,
        13'b1110010_1_00111,
        13'b1000001_0_00101,
        13'b0110100_1_01011
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        err_clr = '1; tick(); err_clr = '0;
        serr_cnt = 0; cpl_cnt = 0; retry_cnt = 0;
    endtask

    // start, one errored phase (perr_cycles long), end; returns drain seen before end
    task automatic run_txn(input bit msg, input int perr_cycles, input bit disc, output bit drain);
        txn_is_msg = msg; txn_start = 1; tick(); txn_start = 0;
        perr_in = (perr_cycles > 0);
        for (int k = 1; k < perr_cycles; k++) tick();
        tick(); perr_in = 0;
        disc_in = disc; tick(); disc_in = 0;
        drain = drain_hold;
        txn_end = 1; tick(); txn_end = 0;
        tick(2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit dr;
        tick(3);
        // R1 reset state
        check(err_sts == 0, "R1 sts", err_sts, 0);
        check({serr_pulse, retry_req, cpl_ok, drain_hold} == 0, "R1 outputs",
              {serr_pulse, retry_req, cpl_ok, drain_hold}, 0);
        rst = 0; tick();

        // table walk: R3 R4 R5 R6 R7 R8
        for (int v = 0; v < 8; v++) begin
            {mode_split, en_serr, en_recov, mask_mpe, mask_serr, en_serr_det_int} = VEC[v][11:6];
            en_perr_resp = 1;
            clear_all();
            run_txn(VEC[v][12], 1, 0, dr);
            check(err_sts == VEC[v][4:0], "R3/R6/R7 sts", err_sts, VEC[v][4:0]);
            check(serr_cnt == int'(VEC[v][5]), VEC[v][12] ? "R5 serr" : "R4 serr",
                  serr_cnt, VEC[v][5]);
            check(cpl_cnt == int'(VEC[v][12]), VEC[v][12] ? "R5 cpl" : "R8 cpl",
                  cpl_cnt, VEC[v][12]);
            if (!VEC[v][12]) check(dr == 1, "R8 drain", dr, 1);
        end

        // R2 response disabled: no effect
        {mode_split, en_serr, en_recov, mask_mpe, mask_serr, en_serr_det_int} = 6'b110001;
        en_perr_resp = 0;
        clear_all();
        run_txn(0, 1, 0, dr);
        check(err_sts == 0, "R2 disabled sts", err_sts, 0);
        check(serr_cnt == 0, "R2 disabled serr", serr_cnt, 0);
        check(dr == 0, "R2 disabled drain", dr, 0);
        check(cpl_cnt == 1, "R8 clean cpl", cpl_cnt, 1);
        en_perr_resp = 1;

        // R12 repeated errors in one transaction
        clear_all();
        run_txn(0, 3, 0, dr);
        check(serr_cnt == 1, "R12 one event", serr_cnt, 1);

        // R11 partial clear
        err_clr = 5'b00001; tick(); err_clr = '0; tick();
        check(err_sts == 5'b11110, "R11 clear", err_sts, 5'b11110);
        // R11 set wins over clear
        err_clr = '1; split_perr = 1; tick(); err_clr = '0; split_perr = 0; tick();
        check(err_sts == 5'b11111, "R11 set wins", err_sts, 5'b11111);

        // R10 split error in split mode and in conventional mode
        clear_all();
        split_perr = 1; tick(); split_perr = 0; tick();
        check(err_sts == 5'b11111, "R10 split sts", err_sts, 5'b11111);
        check(serr_cnt == 1, "R10 split serr", serr_cnt, 1);
        mode_split = 0;
        clear_all();
        split_perr = 1; tick(); split_perr = 0; tick();
        check(err_sts == 0, "R10 conv ignored", err_sts, 0);
        check(serr_cnt == 0, "R10 conv serr", serr_cnt, 0);
        mode_split = 1;

        // R9 disconnect with and without error
        clear_all();
        run_txn(0, 1, 1, dr);
        check(retry_cnt == 1, "R9 retry", retry_cnt, 1);
        clear_all();
        run_txn(0, 0, 1, dr);
        check(retry_cnt == 0, "R9 clean no retry", retry_cnt, 0);
        check(cpl_cnt == 1, "R9 clean cpl", cpl_cnt, 1);

        // R1 reset mid-run clears status
        clear_all();
        split_perr = 1; tick(); split_perr = 0;
        rst = 1; tick(); rst = 0; tick();
        check(err_sts == 0, "R1 reset clears", err_sts, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule